// File: doc/BRIEF.md
# Character Bank Registers with Nibble Loading

This block holds eight bank numbers for the character (pattern) memory of a game cartridge. The picture processor's 8 KiB pattern space splits into eight 1 KiB windows, and each window takes its page from one register. The CPU loads each register four bits at a time with memory-mapped writes. The write that loads the upper four bits can also carry four extension bits, which widens the page to 12 bits. A fixed pair of page numbers is routed to on-board RAM instead of ROM. The routing decision is taken when the bank is written, and it stays with the bank until the next write to that bank.

An optional variant mode, chosen by parameter, reserves two page values as commands. One clears an internal routing flag and the other sets it. A command write changes no window's mapping. While the flag is clear, the two RAM pages go to ROM like any other page.

Top module: `chr_bank_regs`

## Requirements
- R1: During and directly after reset, bank i maps to page i (i = 0..7) with ROM selected, and the routing flag is clear.
- R2: A write is decoded from address bits [15:12] and bits [3:2] only. Regions 0xB, 0xC, 0xD and 0xE each hold two banks: (region - 0xB)*2 + bit 3 gives the bank. Writes to any other region change nothing.
- R3: A write with address bit 2 = 0 replaces bits [3:0] of the bank's 8-bit register with data[3:0]. The bank's page becomes that 8-bit value with the extension bits zero.
- R4: A write with address bit 2 = 1 replaces bits [7:4] of the register with data[3:0]. The bank's page becomes {data[7:4], register}.
- R5: The character address is {page of bank ppu_addr[12:10], ppu_addr[9:0]}. The RAM select output is the latched routing bit of that same bank.
- R6: In the base mode, a bank written with page 0x004 or 0x005 selects RAM. Every other page, including 0x104, selects ROM.
- R7: A bank's routing bit is fixed by the write to that bank. Later writes to other banks, or changes of the routing flag, leave it unchanged.
- R8: In variant mode, a write that forms page 0x088 clears the routing flag and one that forms 0x0C8 sets it. Neither changes any bank's page or routing bit, but the 8-bit register still takes the new nibble.
- R9: In variant mode, pages 0x004 and 0x005 select RAM only if the routing flag is set when they are written. Otherwise they select ROM.
- R10: In the base mode, 0x088 and 0x0C8 are ordinary pages that map like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| ppu_addr_i | input | 13 | Pattern-space address from the picture processor |
| chr_addr_o | output | 22 | Character memory address {page, offset} |
| chr_ram_sel_o | output | 1 | 1 = access goes to on-board RAM, 0 = ROM |

## Verification
The bench builds two instances with default widths: one with the variant mode off and one with it on, and both receive the same write stream. The variant instance exposes the routing flag and the command pages. The base instance shows that the same writes, with values 0x088 and 0x0C8, land as ordinary pages. Comparing the two instances on every cycle, while the picture address sweeps all eight windows, shows whether the per-bank routing bit really stays latched when the flag later changes.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  localparam int unsigned CPU_AW     = 16;
  localparam int unsigned CPU_DW     = 8;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned NUM_BANKS  = 8;
  localparam int unsigned BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int unsigned REG_W      = 2 * NIB_W;
  localparam int unsigned EXT_W      = CPU_DW - NIB_W;
  localparam int unsigned PAGE_W     = REG_W + EXT_W;

  typedef struct packed {
    logic                  hit;
    logic [BANK_IDX_W-1:0] idx;
    logic                  hi_half;
  } wr_dec_t;
endpackage

// File: rtl/chr_wr_decode.sv
module chr_wr_decode
  import chr_bank_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [CPU_AW-1:0] addr_i,
  output wr_dec_t           dec_o
);
  logic [3:0] region;
  logic       in_map;
  logic [1:0] pair;
  logic       unused_addr;

  assign unused_addr = ^{addr_i[11:4], addr_i[1:0]};

  always_comb begin
    region        = addr_i[15:12];
    in_map        = (region >= 4'hB) && (region <= 4'hE);
    pair          = 2'(region - 4'hB);
    dec_o.hit     = wr_en_i && in_map;
    dec_o.idx     = BANK_IDX_W'({pair, addr_i[3]});
    dec_o.hi_half = addr_i[2];
  end
endmodule

// File: rtl/chr_bank_slot.sv
module chr_bank_slot
  import chr_bank_pkg::*;
#(
  parameter int unsigned IDX      = 0,
  parameter int unsigned RAM_PG_A = 4,
  parameter int unsigned RAM_PG_B = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              hi_half_i,
  input  logic [CPU_DW-1:0] data_i,
  input  logic              commit_ok_i,
  input  logic              ram_ok_i,
  output logic [PAGE_W-1:0] cand_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              ram_o
);
  logic [REG_W-1:0] nib_q, nib_d;
  logic             ram_d;

  always_comb begin
    if (hi_half_i) begin
      nib_d  = {data_i[NIB_W-1:0], nib_q[NIB_W-1:0]};
      cand_o = {data_i[CPU_DW-1:NIB_W], nib_d};
    end else begin
      nib_d  = {nib_q[REG_W-1:NIB_W], data_i[NIB_W-1:0]};
      cand_o = {EXT_W'(0), nib_d};
    end
    ram_d = ((cand_o == PAGE_W'(RAM_PG_A)) || (cand_o == PAGE_W'(RAM_PG_B))) && ram_ok_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nib_q  <= REG_W'(IDX);
      page_o <= PAGE_W'(IDX);
      ram_o  <= 1'b0;
    end else if (sel_i) begin
      nib_q <= nib_d;
      if (commit_ok_i) begin
        page_o <= cand_o;
        ram_o  <= ram_d;
      end
    end
  end
endmodule

// File: rtl/chr_page_switch.sv
module chr_page_switch
  import chr_bank_pkg::*;
#(
  parameter bit                VARIANT_EN = 1'b0,
  parameter logic [PAGE_W-1:0] MAGIC_CLR  = 12'h088,
  parameter logic [PAGE_W-1:0] MAGIC_SET  = 12'h0C8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [PAGE_W-1:0] cand_i,
  output logic              sw_o,
  output logic              magic_o,
  output logic              ram_ok_o
);
  if (VARIANT_EN) begin : g_variant
    logic sw_q, is_clr, is_set;
    assign is_clr  = (cand_i == MAGIC_CLR);
    assign is_set  = (cand_i == MAGIC_SET);
    assign magic_o = wr_hit_i && (is_clr || is_set);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                sw_q <= 1'b0;
      else if (wr_hit_i && is_set) sw_q <= 1'b1;
      else if (wr_hit_i && is_clr) sw_q <= 1'b0;
    end

    assign sw_o     = sw_q;
    assign ram_ok_o = sw_q;
  end else begin : g_base
    logic unused_sw;
    assign unused_sw = ^{clk_i, rst_ni, wr_hit_i, cand_i};
    assign sw_o      = 1'b0;
    assign magic_o   = 1'b0;
    assign ram_ok_o  = 1'b1;
  end
endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_bank_pkg::*;
#(
  parameter bit                VARIANT_EN = 1'b0,
  parameter int unsigned       PPU_AW     = 13,
  parameter int unsigned       RAM_PG_A   = 4,
  parameter int unsigned       RAM_PG_B   = 5,
  parameter logic [PAGE_W-1:0] MAGIC_CLR  = 12'h088,
  parameter logic [PAGE_W-1:0] MAGIC_SET  = 12'h0C8,
  localparam int unsigned      WIN_W      = PPU_AW - BANK_IDX_W,
  localparam int unsigned      CHR_AW     = PAGE_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CPU_AW-1:0] wr_addr_i,
  input  logic [CPU_DW-1:0] wr_data_i,
  input  logic [PPU_AW-1:0] ppu_addr_i,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic              chr_ram_sel_o
);
  wr_dec_t                             dec;
  logic [NUM_BANKS-1:0][PAGE_W-1:0]    cand_pg;
  logic [NUM_BANKS-1:0][PAGE_W-1:0]    page_q;
  logic [NUM_BANKS-1:0]                ram_q;
  logic [PAGE_W-1:0]                   cand_sel;
  logic                                sw_q, magic, ram_ok;
  logic [BANK_IDX_W-1:0]               rd_bank;

  chr_wr_decode i_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (wr_addr_i),
    .dec_o   (dec)
  );

  assign cand_sel = cand_pg[dec.idx];

  chr_page_switch #(
    .VARIANT_EN (VARIANT_EN),
    .MAGIC_CLR  (MAGIC_CLR),
    .MAGIC_SET  (MAGIC_SET)
  ) i_sw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (dec.hit),
    .cand_i   (cand_sel),
    .sw_o     (sw_q),
    .magic_o  (magic),
    .ram_ok_o (ram_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    chr_bank_slot #(
      .IDX      (b),
      .RAM_PG_A (RAM_PG_A),
      .RAM_PG_B (RAM_PG_B)
    ) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (dec.hit && (dec.idx == BANK_IDX_W'(b))),
      .hi_half_i   (dec.hi_half),
      .data_i      (wr_data_i),
      .commit_ok_i (!magic),
      .ram_ok_i    (ram_ok),
      .cand_o      (cand_pg[b]),
      .page_o      (page_q[b]),
      .ram_o       (ram_q[b])
    );
  end

  assign rd_bank       = ppu_addr_i[PPU_AW-1 -: BANK_IDX_W];
  assign chr_addr_o    = {page_q[rd_bank], ppu_addr_i[WIN_W-1:0]};
  assign chr_ram_sel_o = ram_q[rd_bank];
endmodule

// File: rtl/chr_bank_regs_chk.sv
module chr_bank_regs_chk
  import chr_bank_pkg::*;
#(
  parameter bit          VARIANT_EN = 1'b0,
  parameter int unsigned PPU_AW     = 13,
  parameter int unsigned RAM_PG_A   = 4,
  parameter int unsigned RAM_PG_B   = 5,
  localparam int unsigned WIN_W     = PPU_AW - BANK_IDX_W,
  localparam int unsigned CHR_AW    = PAGE_W + WIN_W
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic [CPU_AW-1:0]                wr_addr_i,
  input logic [PPU_AW-1:0]                ppu_addr_i,
  input logic [CHR_AW-1:0]                chr_addr_o,
  input logic                             chr_ram_sel_o,
  input logic [NUM_BANKS-1:0][PAGE_W-1:0] page_q,
  input logic [NUM_BANKS-1:0]             ram_q,
  input logic                             sw_q
);
  logic [PAGE_W-1:0] out_page;
  logic              off_map;
  assign out_page = chr_addr_o[CHR_AW-1:WIN_W];
  assign off_map  = (wr_addr_i[15:12] < 4'hB) || (wr_addr_i[15:12] > 4'hE);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_map_r1: assert (!chr_ram_sel_o && !sw_q &&
                              out_page == PAGE_W'(ppu_addr_i[PPU_AW-1 -: BANK_IDX_W]));
    end
  end

  p_off_map_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off_map) |=> ($stable(page_q) && $stable(ram_q) && $stable(sw_q)));

  p_ram_pages_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_ram_sel_o |-> (out_page == PAGE_W'(RAM_PG_A) || out_page == PAGE_W'(RAM_PG_B)));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(page_q) && $stable(ram_q)));

  if (VARIANT_EN) begin : g_var
    p_flag_set_keeps_map_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_q) |-> ($stable(page_q) && $stable(ram_q)));
    p_flag_clr_keeps_map_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sw_q) |-> ($stable(page_q) && $stable(ram_q)));
    p_ram_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(ram_q & ~$past(ram_q))) |-> sw_q);
  end
endmodule

bind chr_bank_regs chr_bank_regs_chk #(
  .VARIANT_EN (VARIANT_EN),
  .PPU_AW     (PPU_AW),
  .RAM_PG_A   (RAM_PG_A),
  .RAM_PG_B   (RAM_PG_B)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .ppu_addr_i    (ppu_addr_i),
  .chr_addr_o    (chr_addr_o),
  .chr_ram_sel_o (chr_ram_sel_o),
  .page_q        (page_q),
  .ram_q         (ram_q),
  .sw_q          (sw_q)
);

// File: tb/test_chr_bank_regs.sv
`timescale 1ns/1ps
module test_chr_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] waddr = '0;
  logic [7:0]  wdata = '0;
  logic [12:0] ppu = '0;
  logic [12:0] ppu_force = '0;
  logic        sweep_en = 1'b1;
  logic        done = 1'b0;
  logic [21:0] out_addr [2];
  logic        out_ram  [2];
  int          total = 0;
  int          bad = 0;

  int m_nib [2][8];
  int m_pg  [2][8];
  bit m_ram [2][8];
  bit m_sw  [2];

  always #2.5 clk = ~clk;

  chr_bank_regs #(.VARIANT_EN(1'b0)) i_chr_bank_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_addr_i(waddr), .wr_data_i(wdata),
    .ppu_addr_i(ppu), .chr_addr_o(out_addr[0]), .chr_ram_sel_o(out_ram[0]));

  chr_bank_regs #(.VARIANT_EN(1'b1)) i_chr_bank_regs_var (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_addr_i(waddr), .wr_data_i(wdata),
    .ppu_addr_i(ppu), .chr_addr_o(out_addr[1]), .chr_ram_sel_o(out_ram[1]));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  function automatic void model_write(int v, logic [15:0] a, logic [7:0] d);
    int region, idx, pg;
    region = int'(a[15:12]);
    if (region < 11 || region > 14) return;
    idx = (region - 11) * 2 + int'(a[3]);
    if (a[2]) begin
      m_nib[v][idx] = (m_nib[v][idx] & 'h0F) | ((int'(d) & 'hF) << 4);
      pg = m_nib[v][idx] + (int'(d) >> 4) * 256;
    end else begin
      m_nib[v][idx] = (m_nib[v][idx] & 'hF0) | (int'(d) & 'hF);
      pg = m_nib[v][idx];
    end
    if (v == 1 && pg == 'h88) m_sw[v] = 1'b0;
    else if (v == 1 && pg == 'hC8) m_sw[v] = 1'b1;
    else begin
      m_pg[v][idx]  = pg;
      m_ram[v][idx] = (pg == 4 || pg == 5) && !(v == 1 && !m_sw[v]);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        m_sw[v] = 1'b0;
        for (int b = 0; b < 8; b++) begin
          m_nib[v][b] = b; m_pg[v][b] = b; m_ram[v][b] = 1'b0;
        end
      end
    end else if (wr) begin
      for (int v = 0; v < 2; v++) model_write(v, waddr, wdata);
    end
  end

  // per-cycle comparison, then move the picture address
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int v = 0; v < 2; v++) begin
        int b;
        logic [21:0] e;
        b = int'(ppu[12:10]);
        e = 22'(m_pg[v][b] * 1024 + int'(ppu[9:0]));
        chk(out_addr[v] === e, "R5 address vs model", 32'(out_addr[v]), 32'(e));
        chk(out_ram[v] === m_ram[v][b], "R5 select vs model", 32'(out_ram[v]), 32'(m_ram[v][b]));
      end
    end
    ppu <= sweep_en ? ppu + 13'h135 : ppu_force;
  end

  task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic check_bank(input int v, input int b, input int exp_pg, input bit exp_ram, input string tag);
    logic [21:0] e;
    sweep_en  = 1'b0;
    ppu_force = 13'(b * 1024 + 'h2A5);
    @(negedge clk); @(negedge clk); #1;
    e = 22'(exp_pg * 1024 + 'h2A5);
    chk(out_addr[v] === e, tag, 32'(out_addr[v]), 32'(e));
    chk(out_ram[v] === exp_ram, tag, 32'(out_ram[v]), 32'(exp_ram));
    sweep_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values seen while still in reset and right after release
    check_bank(0, 6, 6, 1'b0, "R1 bank6 in reset");
    rst_n = 1'b1;
    for (int b = 0; b < 8; b++) check_bank(0, b, b, 1'b0, "R1 base reset page");
    check_bank(1, 4, 4, 1'b0, "R1 variant reset page");
    check_bank(1, 5, 5, 1'b0, "R1 variant reset page");

    wr_cycle(16'hB000, 8'h0A);
    check_bank(0, 0, 'h00A, 1'b0, "R3 low nibble");
    wr_cycle(16'hB004, 8'h35);
    check_bank(0, 0, 'h35A, 1'b0, "R4 high nibble with extension");
    check_bank(1, 0, 'h35A, 1'b0, "R4 variant high nibble");
    wr_cycle(16'hB008, 8'h04);
    check_bank(0, 1, 'h004, 1'b1, "R6 page 4 to RAM");
    check_bank(1, 1, 'h004, 1'b0, "R9 page 4 ROM with flag clear");

    wr_cycle(16'hF000, 8'h07);
    wr_cycle(16'hA004, 8'hFF);
    wr_cycle(16'h9008, 8'h55);
    check_bank(0, 0, 'h35A, 1'b0, "R2 off-map write ignored");
    check_bank(0, 1, 'h004, 1'b1, "R2 off-map write ignored");
    check_bank(1, 7, 7, 1'b0, "R2 off-map write ignored");

    wr_cycle(16'hC01C, 8'h10);
    check_bank(0, 3, 'h103, 1'b0, "R2 mirrored address bits");
    check_bank(0, 2, 2, 1'b0, "R2 neighbour untouched");

    wr_cycle(16'hD000, 8'h08);
    wr_cycle(16'hD004, 8'h08);
    check_bank(0, 4, 'h088, 1'b0, "R10 0x088 ordinary");
    check_bank(1, 4, 'h008, 1'b0, "R8 clear command keeps map");

    wr_cycle(16'hD00C, 8'h0C);
    check_bank(1, 5, 'h0C5, 1'b0, "R4 bank5 high");
    wr_cycle(16'hD008, 8'h08);
    check_bank(0, 5, 'h0C8, 1'b0, "R10 0x0C8 ordinary");
    check_bank(1, 5, 'h0C5, 1'b0, "R8 set command keeps map");

    wr_cycle(16'hE000, 8'h05);
    check_bank(0, 6, 'h005, 1'b1, "R6 page 5 to RAM");
    check_bank(1, 6, 'h005, 1'b1, "R9 page 5 RAM with flag set");
    check_bank(1, 1, 'h004, 1'b0, "R7 earlier routing kept");

    wr_cycle(16'hD004, 8'h08);
    check_bank(1, 4, 'h008, 1'b0, "R8 clear again keeps map");
    wr_cycle(16'hE008, 8'h04);
    check_bank(0, 7, 'h004, 1'b1, "R6 page 4 to RAM");
    check_bank(1, 7, 'h004, 1'b0, "R9 flag cleared gives ROM");
    check_bank(1, 6, 'h005, 1'b1, "R7 routing survives flag clear");

    wr_cycle(16'hE004, 8'h10);
    check_bank(0, 6, 'h105, 1'b0, "R6 page 0x105 is ROM");
    check_bank(1, 6, 'h105, 1'b0, "R6 page 0x105 is ROM");

    // mixed traffic checked against the reference every cycle
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      a[15:12] = 4'($urandom_range(8, 15));
      d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d[7:4] = 4'h0;
      if ($urandom_range(0, 5) == 0) d[3:0] = 4'($urandom_range(4, 5));
      if ($urandom_range(0, 7) == 0) d = 8'h08;
      wr_cycle(a, d);
      if ($urandom_range(0, 2) == 0) @(negedge clk);
    end
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule